// File: doc/BRIEF.md
# Multi-mode operand address generator

This block resolves the second operand of a two-operand register-memory instruction. A request carries a mode code, two register values (a base and an index), a displacement/absolute field, an immediate field and a 2-bit scale selector. The scale selector picks a data-size step d of 1, 2, 4 or 8. The block then does one of three things:

- It passes a register value or the immediate straight through.
- It issues one memory read at a computed effective address.
- In memory-indirect mode, it issues two dependent reads: the word returned by the first read is the address of the second.

Each read is a level request held until the memory answers with a ready strobe. When the operand is available the block pulses a completion strobe. In the post-increment and pre-decrement modes it also pulses a base-register writeback strobe with the updated base value. The register file, the memory and the operand arithmetic are outside the block.

Top module: `opaddr_gen`

## Requirements
- R1: After synchronous reset, busy_o, done_o, mem_req_o and wb_en_o are all 0.
- R2: Mode code 0 (register) and the unused codes 10 to 15 make no memory read. They complete with op_src_o = 0 and op_value_o = the index register value rb_i.
- R3: Mode 1 (immediate) makes no memory read and completes with op_src_o = 1 and op_value_o = imm_i.
- R4: Each single-read mode issues exactly one read and completes with op_src_o = 2 and op_value_o = the data returned. All address sums wrap modulo 2^W. The read addresses are:
  - mode 2 (displacement): disp_i + ra_i
  - mode 3 (register indirect): ra_i
  - mode 4 (base plus index): ra_i + rb_i
  - mode 5 (absolute): disp_i
- R5: Mode 6 (memory indirect) issues two reads. The first is at ra_i. The second is at the word returned by the first. op_value_o is the word returned by the second read.
- R6: Mode 7 (post-increment) reads at ra_i. On completion it presents wb_val_o = ra_i + d, where d = 1 << scale_i.
- R7: Mode 8 (pre-decrement) reads at ra_i - d. On completion it presents wb_val_o = ra_i - d.
- R8: Mode 9 (scaled index) reads at disp_i + ra_i + (rb_i << scale_i).
- R9: While mem_req_o is high and mem_rdy_i is low, mem_req_o stays high and mem_addr_o stays stable in the next cycle. A cycle with both high completes exactly one read.
- R10: done_o is high for exactly one cycle per request.
- R11: wb_en_o is high only in the done_o cycle, and only in modes 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, accepted when idle |
| mode_i | input | 4 | Addressing mode code |
| ra_i | input | W | Base register value |
| rb_i | input | W | Index / second register value |
| disp_i | input | W | Displacement or absolute address field |
| imm_i | input | W | Immediate field |
| scale_i | input | 2 | Step select, d = 1 << scale_i |
| mem_rdy_i | input | 1 | Memory read ready |
| mem_rdata_i | input | W | Memory read data |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Operand valid strobe |
| op_src_o | output | 2 | Operand source: 0 register, 1 immediate, 2 memory |
| op_value_o | output | W | Operand value, valid with done_o |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | W | Memory read address |
| wb_en_o | output | 1 | Base-register writeback strobe |
| wb_val_o | output | W | Base-register writeback value |

## Verification
A sequencer stuck in a wrong state shows up at the ports within a few cycles. It appears as an extra or missing read in the access log, a read at the wrong address, or a completion strobe that never arrives, repeats, or fires without the writeback it needs.

A wrong address or a wrong stored intermediate word shows up at the first read of that request. The memory model returns data that is a distinct function of its address, so any address error also corrupts the final operand value, and the bench sees it in the completion cycle. The sweep covers every mode code, every scale, wrapping operand values and ready latencies of zero to two cycles.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    typedef enum logic [3:0] {
        AM_REG    = 4'd0,
        AM_IMM    = 4'd1,
        AM_DISP   = 4'd2,
        AM_IND    = 4'd3,
        AM_BIDX   = 4'd4,
        AM_ABS    = 4'd5,
        AM_MIND   = 4'd6,
        AM_POSTI  = 4'd7,
        AM_PRED   = 4'd8,
        AM_SCALED = 4'd9
    } amode_t;

    typedef enum logic [1:0] {
        SRC_REG = 2'd0,
        SRC_IMM = 2'd1,
        SRC_MEM = 2'd2
    } osrc_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_FETCH1 = 3'd2,
        ST_FETCH2 = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_t;

    function automatic logic mode_reads_mem(input logic [3:0] m);
        return (m >= 4'd2) && (m <= 4'd9);
    endfunction

    function automatic logic mode_writes_base(input logic [3:0] m);
        return (m == AM_POSTI) || (m == AM_PRED);
    endfunction

    function automatic osrc_t mode_source(input logic [3:0] m);
        if (m == AM_IMM)        return SRC_IMM;
        if (mode_reads_mem(m))  return SRC_MEM;
        return SRC_REG;
    endfunction

endpackage

// File: rtl/opaddr_calc.sv
module opaddr_calc
    import opaddr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   mode,
    input  logic [W-1:0] ra,
    input  logic [W-1:0] rb,
    input  logic [W-1:0] disp,
    input  logic [1:0]   scale,
    output logic [W-1:0] ea,
    output logic [W-1:0] base_next
);
    logic [W-1:0] step;
    logic [W-1:0] rb_scaled;

    assign step      = W'(1) << scale;
    assign rb_scaled = rb << scale;

    always_comb begin
        case (mode)
            AM_DISP:   ea = disp + ra;
            AM_BIDX:   ea = ra + rb;
            AM_ABS:    ea = disp;
            AM_PRED:   ea = ra - step;
            AM_SCALED: ea = disp + ra + rb_scaled;
            default:   ea = ra;
        endcase
    end

    always_comb begin
        case (mode)
            AM_POSTI: base_next = ra + step;
            AM_PRED:  base_next = ra - step;
            default:  base_next = ra;
        endcase
    end
endmodule

// File: rtl/opaddr_seq.sv
module opaddr_seq
    import opaddr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       needs_mem,
    input  logic       indirect,
    input  logic       mem_rdy,
    output seq_state_t state,
    output logic       accept,
    output logic       calc,
    output logic       take1,
    output logic       take2,
    output logic       mem_req,
    output logic       done
);
    seq_state_t nxt;

    assign accept  = (state == ST_IDLE) && start;
    assign calc    = (state == ST_ADDR);
    assign take1   = (state == ST_FETCH1) && mem_rdy;
    assign take2   = (state == ST_FETCH2) && mem_rdy;
    assign mem_req = (state == ST_FETCH1) || (state == ST_FETCH2);
    assign done    = (state == ST_DONE);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:   if (start) nxt = ST_ADDR;
            ST_ADDR:   nxt = needs_mem ? ST_FETCH1 : ST_DONE;
            ST_FETCH1: if (mem_rdy) nxt = indirect ? ST_FETCH2 : ST_DONE;
            ST_FETCH2: if (mem_rdy) nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    p_fetch2_indirect_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH2) |-> indirect);

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
    import opaddr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [3:0]   mode_i,
    input  logic [W-1:0] ra_i,
    input  logic [W-1:0] rb_i,
    input  logic [W-1:0] disp_i,
    input  logic [W-1:0] imm_i,
    input  logic [1:0]   scale_i,
    input  logic         mem_rdy_i,
    input  logic [W-1:0] mem_rdata_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [1:0]   op_src_o,
    output logic [W-1:0] op_value_o,
    output logic         mem_req_o,
    output logic [W-1:0] mem_addr_o,
    output logic         wb_en_o,
    output logic [W-1:0] wb_val_o
);
    logic [3:0]   mode_q;
    logic [W-1:0] ra_q, rb_q, disp_q, imm_q;
    logic [1:0]   scale_q;
    logic [W-1:0] addr_q, data_q, wb_q;
    logic [W-1:0] ea, base_next;
    seq_state_t   state;
    logic         accept, calc, take1, take2, done;
    osrc_t        src;

    opaddr_calc #(.W(W)) u_calc (
        .mode(mode_q), .ra(ra_q), .rb(rb_q), .disp(disp_q), .scale(scale_q),
        .ea(ea), .base_next(base_next)
    );

    opaddr_seq u_seq (
        .clk(clk), .rst(rst), .start(start_i),
        .needs_mem(mode_reads_mem(mode_q)),
        .indirect(mode_q == AM_MIND),
        .mem_rdy(mem_rdy_i),
        .state(state), .accept(accept), .calc(calc),
        .take1(take1), .take2(take2), .mem_req(mem_req_o), .done(done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            ra_q    <= '0;
            rb_q    <= '0;
            disp_q  <= '0;
            imm_q   <= '0;
            scale_q <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            wb_q    <= '0;
        end else begin
            if (accept) begin
                mode_q  <= mode_i;
                ra_q    <= ra_i;
                rb_q    <= rb_i;
                disp_q  <= disp_i;
                imm_q   <= imm_i;
                scale_q <= scale_i;
            end
            if (calc) begin
                addr_q <= ea;
                wb_q   <= base_next;
            end
            if (take1) begin
                data_q <= mem_rdata_i;
                if (mode_q == AM_MIND) addr_q <= mem_rdata_i;
            end
            if (take2) data_q <= mem_rdata_i;
        end
    end

    assign src        = mode_source(mode_q);
    assign op_src_o   = src;
    assign busy_o     = (state != ST_IDLE);
    assign done_o     = done;
    assign mem_addr_o = addr_q;
    assign wb_en_o    = done && mode_writes_base(mode_q);
    assign wb_val_o   = wb_q;

    always_comb begin
        case (src)
            SRC_IMM: op_value_o = imm_q;
            SRC_MEM: op_value_o = data_q;
            default: op_value_o = rb_q;
        endcase
    end

    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)));

    p_wb_in_done_r11: assert property (@(posedge clk) disable iff (rst)
        wb_en_o |-> done_o);

    p_req_busy_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> (busy_o && !done_o));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!mem_req_o && !done_o && !wb_en_o));
endmodule

// File: tb/sim_opaddr_gen.sv
module sim_opaddr_gen;
    localparam int W = 16;
    localparam time TCLK = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [3:0]   mode_i = '0;
    logic [W-1:0] ra_i = '0, rb_i = '0, disp_i = '0, imm_i = '0;
    logic [1:0]   scale_i = '0;
    logic         mem_rdy_i;
    logic [W-1:0] mem_rdata_i;
    logic         busy_o, done_o, mem_req_o, wb_en_o;
    logic [1:0]   op_src_o;
    logic [W-1:0] op_value_o, mem_addr_o, wb_val_o;

    int compared = 0;
    int mismatched = 0;
    int latency = 0;
    int wcnt = 0;
    int acc_total = 0;
    int done_total = 0;
    int wb_total = 0;
    logic [W-1:0] acc_log [0:7];

    opaddr_gen #(.W(W)) u0 (.*);

    always #(TCLK/2) clk = ~clk;

    function automatic logic [W-1:0] memf(input logic [W-1:0] a);
        return W'(a * 16'h9E37 + 16'h1234);
    endfunction

    assign mem_rdata_i = memf(mem_addr_o);
    assign mem_rdy_i   = mem_req_o && (wcnt == latency);

    always @(posedge clk) begin
        if (mem_req_o && !mem_rdy_i) wcnt <= wcnt + 1;
        else                         wcnt <= 0;
        if (mem_req_o && mem_rdy_i) begin
            acc_log[acc_total % 8] <= mem_addr_o;
            acc_total <= acc_total + 1;
        end
        if (done_o)  done_total <= done_total + 1;
        if (wb_en_o) wb_total <= wb_total + 1;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input int m, input int s, input logic [W-1:0] ra,
                          input logic [W-1:0] rb, input logic [W-1:0] dsp,
                          input logic [W-1:0] imm);
        int a0, d0, w0, cyc;
        logic [W-1:0] d, e1, e2, ev, ewb;
        int nacc, esrc;
        logic ewbe;
        string rq;
        d = W'(1) << s;
        nacc = 1; esrc = 2; ewbe = 1'b0; ewb = '0; e1 = '0; e2 = '0;
        case (m)
            1: begin nacc = 0; esrc = 1; ev = imm; rq = "R3"; end
            2: begin e1 = dsp + ra; rq = "R4"; end
            3: begin e1 = ra; rq = "R4"; end
            4: begin e1 = ra + rb; rq = "R4"; end
            5: begin e1 = dsp; rq = "R4"; end
            6: begin nacc = 2; e1 = ra; e2 = memf(ra); rq = "R5"; end
            7: begin e1 = ra; ewbe = 1'b1; ewb = ra + d; rq = "R6"; end
            8: begin e1 = ra - d; ewbe = 1'b1; ewb = ra - d; rq = "R7"; end
            9: begin e1 = dsp + ra + (rb << s); rq = "R8"; end
            default: begin nacc = 0; esrc = 0; ev = rb; rq = "R2"; end
        endcase
        if (nacc == 1) ev = memf(e1);
        if (nacc == 2) ev = memf(e2);

        @(negedge clk);
        a0 = acc_total; d0 = done_total; w0 = wb_total;
        mode_i = 4'(m); scale_i = 2'(s);
        ra_i = ra; rb_i = rb; disp_i = dsp; imm_i = imm;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (!done_o && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        chk(rq, "completion reached", done_o, 1);
        chk(rq, "operand source", op_src_o, esrc);
        chk(rq, "operand value", op_value_o, ev);
        chk(rq, "read count", acc_total - a0, nacc);
        if (nacc >= 1) chk(rq, "first read address", acc_log[a0 % 8], e1);
        if (nacc == 2) chk("R5", "second read address", acc_log[(a0 + 1) % 8], e2);
        chk("R11", "writeback strobe", wb_en_o, ewbe);
        if (ewbe) chk(rq, "writeback value", wb_val_o, ewb);
        @(negedge clk);
        chk("R10", "done pulse count", done_total - d0, 1);
        chk("R10", "done drops", done_o, 0);
        chk("R11", "writeback pulse count", wb_total - w0, ewbe ? 1 : 0);
        chk("R9", "no request after completion", mem_req_o, 0);
    endtask

    initial begin : watchdog
        #(TCLK * 150000);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] pra, prb, pd, pi;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "busy after reset", busy_o, 0);
        chk("R1", "done after reset", done_o, 0);
        chk("R1", "request after reset", mem_req_o, 0);
        chk("R1", "writeback after reset", wb_en_o, 0);
        for (int lat = 0; lat < 3; lat++) begin
            latency = lat;  // R9: ready withheld for lat cycles
            for (int p = 0; p < 4; p++) begin
                case (p)
                    0: begin pra = 16'h1000; prb = 16'h0010; pd = 16'h0040; pi = 16'h0ABC; end
                    1: begin pra = 16'h0002; prb = 16'hFFFF; pd = 16'hFFF0; pi = 16'hFFFF; end
                    2: begin pra = 16'hFFFC; prb = 16'h1234; pd = 16'h0007; pi = 16'h0000; end
                    default: begin pra = 16'h5A5A; prb = 16'h8001; pd = 16'h2468; pi = 16'h7F80; end
                endcase
                for (int m = 0; m < 16; m++)
                    for (int s = 0; s < 4; s++)
                        run_op(m, s, pra, prb, pd, pi);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule